// File: doc/BRIEF.md
# Character LCD Init and Write Controller

This block drives a two-row, sixteen-column character display over an eight-bit parallel bus with a register-select line, a read/write line and an enable strobe. After reset it waits out the display's power-up time. It then sends four fixed configuration commands, in order, with the wait that each one needs. Only after that does it accept work from the host.

Host requests arrive on a valid/ready handshake. A request either writes one character at the display's current address or moves that address to a row and column. The display advances its address after every character it stores, so a string needs one position request followed by its characters. The controller never reads the display's busy state. It waits a fixed time after every command instead. Every wait and every strobe phase is a cycle count rounded up from the `CLK_HZ` parameter, so no minimum is cut short at any clock rate.

Top module: `lcd_char_ctrl`

## Requirements
- R1: From reset, `lcd_e` and `req_ready` stay low, and the first rising edge of `lcd_e` comes no earlier than ceil(20 ms × CLK_HZ) clock cycles after reset is released.
- R2: The first four strobes carry RS=0 and the bytes 0x38 (8-bit bus, two lines, 5x8 font), 0x0C (display on, cursor off), 0x01 (clear) and 0x06 (address increment, no shift), in that order.
- R3: From the falling edge of E for one command to the rising edge for the next, at least ceil(1.52 ms × CLK_HZ) cycles pass if the command was RS=0 with byte 0x01. After any other command, at least ceil(37 us × CLK_HZ) cycles pass.
- R4: `req_ready` first rises only after the entry-mode command and its ceil(37 us × CLK_HZ) wait are complete.
- R5: E stays high for at least ceil(220 ns × CLK_HZ) cycles, and its rising edges are at least ceil(500 ns × CLK_HZ) cycles apart.
- R6: RS and DB hold their values for at least ceil(40 ns × CLK_HZ) cycles before E rises and for at least ceil(10 ns × CLK_HZ) cycles after E falls.
- R7: `lcd_rw` is 0 at all times. The controller only writes.
- R8: An accepted request with `req_kind`=0 produces exactly one strobe with RS=1 and DB equal to `req_data`.
- R9: An accepted request with `req_kind`=1 produces exactly one strobe with RS=0 and DB = 0x80 | addr. Here addr = (`req_row` ? 0x40 : 0x00) + min(`req_col`, 39).
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the following cycle, and E is never high while `req_ready` is high.
- R11: `req_valid` that is withdrawn before `req_ready` rises has no effect: no strobe results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 1 | 0 = write character, 1 = set position |
| req_data | input | 8 | Character code for a write |
| req_row | input | 1 | Target row for a position request |
| req_col | input | COL_W (6) | Target column for a position request, clamped to 39 |
| lcd_rs | output | 1 | Register select: 1 data, 0 instruction |
| lcd_rw | output | 1 | Read/write select, held at 0 |
| lcd_e | output | 1 | Enable strobe, active high, display latches on its fall |
| lcd_db | output | 8 | Data bus to the display |

## Verification
The bound checker checks the timing rules on every clock cycle. These are the setup and hold stability of RS and DB around both edges of E, the E high width, the gap after each command (which depends on the command), the power-up wait, R/W held low, a quiet bus while ready, and ready dropping after each acceptance. Some behaviour only the bench scenarios can show. One is the order and content of the four configuration bytes. Another is the DDRAM address for every row and every column from 0 to 63, including the clamp above 39. The bench also shows that each character request puts its own code on the bus with RS high, and that a request withdrawn during initialisation produces no strobe.

// File: rtl/lcd_ctrl_pkg.sv
`timescale 1ns/1ps
package lcd_ctrl_pkg;

    // Instruction bytes sent by the controller
    localparam logic [7:0] CMD_FUNC_SET = 8'h38;   // 8-bit bus, 2 lines, 5x8 font
    localparam logic [7:0] CMD_DISP_ON  = 8'h0C;   // display on, cursor off
    localparam logic [7:0] CMD_CLEAR    = 8'h01;   // clear all, address to 0
    localparam logic [7:0] CMD_ENTRY    = 8'h06;   // increment, no shift
    localparam logic       CMD_POS_FLAG = 1'b1;    // bit 7 set selects DDRAM address

    localparam int unsigned INIT_LEN = 4;

    // Minimum intervals, in nanoseconds
    localparam longint unsigned NS_POWER = 64'd20_000_000;
    localparam longint unsigned NS_CMD   = 64'd37_000;
    localparam longint unsigned NS_CLEAR = 64'd1_520_000;
    localparam longint unsigned NS_SETUP = 64'd40;
    localparam longint unsigned NS_PULSE = 64'd220;
    localparam longint unsigned NS_HOLD  = 64'd10;
    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

    // Round a time up to whole clock cycles, never below one
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned hz);
        longint unsigned q;
        q = (ns * hz + NS_PER_S - 64'd1) / NS_PER_S;
        if (q == 64'd0) q = 64'd1;
        return 32'(q);
    endfunction

    // Fixed configuration sequence, in issue order
    function automatic logic [7:0] init_byte(input logic [1:0] idx);
        logic [7:0] b;
        case (idx)
            2'd0:    b = CMD_FUNC_SET;
            2'd1:    b = CMD_DISP_ON;
            2'd2:    b = CMD_CLEAR;
            default: b = CMD_ENTRY;
        endcase
        return b;
    endfunction

    typedef enum logic [2:0] {
        ST_POWER,
        ST_ISSUE,
        ST_STROBE,
        ST_GAP,
        ST_IDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_OFF,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD
    } strobe_phase_e;

endpackage

// File: rtl/lcd_ddram_addr.sv
`timescale 1ns/1ps
module lcd_ddram_addr #(
    parameter int unsigned COL_W     = 6,
    parameter int unsigned COLS      = 40,
    parameter int unsigned ROW1_BASE = 64
) (
    input  logic             row,
    input  logic [COL_W-1:0] col,
    output logic [6:0]       addr
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic [COL_W-1:0] col_eff;

    always_comb begin
        col_eff = (col > LAST_COL) ? LAST_COL : col;
        addr    = (row ? 7'(ROW1_BASE) : 7'd0) + 7'(col_eff);
    end
endmodule

// File: rtl/lcd_wait_timer.sv
`timescale 1ns/1ps
module lcd_wait_timer #(
    parameter int unsigned W          = 8,
    parameter int unsigned RESET_LOAD = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
        expire = (cnt_q == W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= W'(RESET_LOAD);
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lcd_bus_strobe.sv
`timescale 1ns/1ps
module lcd_bus_strobe
    import lcd_ctrl_pkg::*;
#(
    parameter int unsigned SU = 1,
    parameter int unsigned PW = 1,
    parameter int unsigned HD = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_rs,
    input  logic [7:0] start_byte,
    output logic       done,
    output logic       lcd_e,
    output logic       lcd_rs,
    output logic [7:0] lcd_db
);
    localparam int unsigned MAX_A = (SU > PW) ? SU : PW;
    localparam int unsigned MAX_V = (MAX_A > HD) ? MAX_A : HD;
    localparam int unsigned PHW   = (MAX_V < 2) ? 1 : $clog2(MAX_V);

    typedef struct packed {
        strobe_phase_e    phase;
        logic [PHW-1:0]   cnt;
        logic             rs;
        logic [7:0]       db;
    } strobe_regs_t;

    strobe_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_OFF: begin
                if (start) begin
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = PHW'(SU - 1);
                    s_d.rs    = start_rs;
                    s_d.db    = start_byte;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_HIGH;
                    s_d.cnt   = PHW'(PW - 1);
                end else begin
                    s_d.cnt = s_q.cnt - PHW'(1);
                end
            end
            PH_HIGH: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = PHW'(HD - 1);
                end else begin
                    s_d.cnt = s_q.cnt - PHW'(1);
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) s_d.phase = PH_OFF;
                else               s_d.cnt   = s_q.cnt - PHW'(1);
            end
            default: s_d.phase = PH_OFF;
        endcase

        done   = (s_q.phase == PH_HOLD) && (s_q.cnt == '0);
        lcd_e  = (s_q.phase == PH_HIGH);
        lcd_rs = s_q.rs;
        lcd_db = s_q.db;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_OFF;
            s_q.cnt   <= '0;
            s_q.rs    <= 1'b0;
            s_q.db    <= 8'h00;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/lcd_char_ctrl.sv
`timescale 1ns/1ps
module lcd_char_ctrl
    import lcd_ctrl_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd50_000_000,
    parameter int unsigned     COL_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_kind,
    input  logic [7:0]       req_data,
    input  logic             req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             lcd_rs,
    output logic             lcd_rw,
    output logic             lcd_e,
    output logic [7:0]       lcd_db
);
    localparam int unsigned T_POWER = ns_to_cycles(NS_POWER, CLK_HZ);
    localparam int unsigned T_CMD   = ns_to_cycles(NS_CMD,   CLK_HZ);
    localparam int unsigned T_CLR   = ns_to_cycles(NS_CLEAR, CLK_HZ);
    localparam int unsigned T_SU    = ns_to_cycles(NS_SETUP, CLK_HZ);
    localparam int unsigned T_PW    = ns_to_cycles(NS_PULSE, CLK_HZ);
    localparam int unsigned T_HD    = ns_to_cycles(NS_HOLD,  CLK_HZ);
    localparam int unsigned TW      = $clog2(T_POWER + 1);
    localparam logic [1:0]  LAST_IDX = 2'(INIT_LEN - 1);

    typedef struct packed {
        seq_state_e  st;
        logic [1:0]  idx;
        logic        in_init;
        logic        cmd_rs;
        logic [7:0]  cmd_byte;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          strobe_start;
    logic          strobe_done;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expire;
    logic [6:0]    pos_addr;

    lcd_ddram_addr #(
        .COL_W     (COL_W),
        .COLS      (40),
        .ROW1_BASE (64)
    ) u_addr (
        .row  (req_row),
        .col  (req_col),
        .addr (pos_addr)
    );

    lcd_wait_timer #(
        .W          (TW),
        .RESET_LOAD (T_POWER)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    lcd_bus_strobe #(
        .SU (T_SU),
        .PW (T_PW),
        .HD (T_HD)
    ) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (strobe_start),
        .start_rs   (r_q.cmd_rs),
        .start_byte (r_q.cmd_byte),
        .done       (strobe_done),
        .lcd_e      (lcd_e),
        .lcd_rs     (lcd_rs),
        .lcd_db     (lcd_db)
    );

    always_comb begin
        r_d          = r_q;
        strobe_start = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = TW'(T_CMD);

        case (r_q.st)
            ST_POWER: begin
                if (tmr_expire) begin
                    r_d.st       = ST_ISSUE;
                    r_d.idx      = 2'd0;
                    r_d.in_init  = 1'b1;
                    r_d.cmd_rs   = 1'b0;
                    r_d.cmd_byte = init_byte(2'd0);
                end
            end
            ST_ISSUE: begin
                strobe_start = 1'b1;
                r_d.st       = ST_STROBE;
            end
            ST_STROBE: begin
                if (strobe_done) begin
                    tmr_load = 1'b1;
                    if (!r_q.cmd_rs && r_q.cmd_byte == CMD_CLEAR) tmr_val = TW'(T_CLR);
                    r_d.st = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_expire) begin
                    if (r_q.in_init && r_q.idx != LAST_IDX) begin
                        r_d.idx      = r_q.idx + 2'd1;
                        r_d.cmd_rs   = 1'b0;
                        r_d.cmd_byte = init_byte(r_q.idx + 2'd1);
                        r_d.st       = ST_ISSUE;
                    end else begin
                        r_d.in_init = 1'b0;
                        r_d.st      = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st = ST_ISSUE;
                    if (req_kind) begin
                        r_d.cmd_rs   = 1'b0;
                        r_d.cmd_byte = {CMD_POS_FLAG, pos_addr};
                    end else begin
                        r_d.cmd_rs   = 1'b1;
                        r_d.cmd_byte = req_data;
                    end
                end
            end
            default: r_d.st = ST_POWER;
        endcase

        req_ready = (r_q.st == ST_IDLE);
        lcd_rw    = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_POWER;
            r_q.idx      <= 2'd0;
            r_q.in_init  <= 1'b1;
            r_q.cmd_rs   <= 1'b0;
            r_q.cmd_byte <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/lcd_char_ctrl_chk.sv
`timescale 1ns/1ps
module lcd_char_ctrl_chk
    import lcd_ctrl_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd50_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic [7:0] lcd_db
);
    localparam int unsigned T_POWER = ns_to_cycles(NS_POWER, CLK_HZ);
    localparam int unsigned T_CMD   = ns_to_cycles(NS_CMD,   CLK_HZ);
    localparam int unsigned T_CLR   = ns_to_cycles(NS_CLEAR, CLK_HZ);
    localparam int unsigned T_PW    = ns_to_cycles(NS_PULSE, CLK_HZ);

    logic [31:0] hi_q, gap_q, pwr_q;
    logic        e_q, long_q, seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            gap_q  <= '0;
            pwr_q  <= '0;
            e_q    <= 1'b0;
            long_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            e_q   <= lcd_e;
            hi_q  <= lcd_e ? hi_q + 32'd1 : 32'd0;
            gap_q <= lcd_e ? 32'd0 : gap_q + 32'd1;
            if (pwr_q < T_POWER) pwr_q <= pwr_q + 32'd1;
            if (e_q && !lcd_e) begin
                seen_q <= 1'b1;
                long_q <= !lcd_rs && (lcd_db == CMD_CLEAR);
            end
        end
    end

    assert_rw_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw == 1'b0);

    assert_quiet_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_e);

    assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_setup_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (hi_q >= T_PW));

    assert_power_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> (pwr_q >= T_POWER));

    assert_cmd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_e) && seen_q) |-> (gap_q >= (long_q ? T_CLR : T_CMD)));

endmodule

bind lcd_char_ctrl lcd_char_ctrl_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_e     (lcd_e),
    .lcd_db    (lcd_db)
);

// File: tb/lcd_char_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_char_ctrl_tb;

    // Small configuration: the controller is told the clock is 4 MHz
    localparam longint unsigned HZ = 64'd4_000_000;

    function automatic longint unsigned cyc_of(input longint unsigned ns);
        longint unsigned q;
        q = (ns * HZ + 64'd999_999_999) / 64'd1_000_000_000;
        return (q == 64'd0) ? 64'd1 : q;
    endfunction

    localparam longint unsigned X_POWER = cyc_of(64'd20_000_000);
    localparam longint unsigned X_CMD   = cyc_of(64'd37_000);
    localparam longint unsigned X_CLR   = cyc_of(64'd1_520_000);
    localparam longint unsigned X_SU    = cyc_of(64'd40);
    localparam longint unsigned X_PW    = cyc_of(64'd220);
    localparam longint unsigned X_HD    = cyc_of(64'd10);
    localparam longint unsigned X_PER   = cyc_of(64'd500);

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_kind, req_row;
    logic [7:0] req_data;
    logic [5:0] req_col;
    logic       req_ready, lcd_rs, lcd_rw, lcd_e;
    logic [7:0] lcd_db;

    always #2.5 clk = ~clk;

    lcd_char_ctrl #(.CLK_HZ(HZ), .COL_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_data(req_data), .req_row(req_row), .req_col(req_col),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Bus monitor, sampled on the falling clock edge
    longint     cyc, stab, hi, lo, last_rise, last_fall, ready_first;
    logic       e_prev;
    logic [8:0] bus_prev, bus_now;
    bit         seen_fall, hold_pend, last_long, ready_seen;
    int         ncap;
    logic [8:0] cap [0:255];

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; stab = 0; hi = 0; lo = 0; last_rise = 0; last_fall = 0;
            e_prev = 1'b0; bus_prev = {lcd_rs, lcd_db};
            seen_fall = 1'b0; hold_pend = 1'b0; last_long = 1'b0;
            ready_seen = 1'b0; ncap = 0;
        end else begin
            cyc++;
            bus_now = {lcd_rs, lcd_db};
            if (bus_now == bus_prev) begin
                stab++;
            end else begin
                if (hold_pend) begin
                    chk((cyc - last_fall) >= X_HD, "R6 hold after E fall", cyc - last_fall, X_HD);
                    hold_pend = 1'b0;
                end
                stab = 0;
            end
            if (lcd_e && !e_prev) begin
                chk(stab >= X_SU, "R6 setup before E rise", stab, X_SU);
                chk(lcd_rw == 1'b0, "R7 rw low at strobe", lcd_rw, 0);
                if (seen_fall) begin
                    chk(lo >= (last_long ? X_CLR : X_CMD), "R3 command gap", lo,
                        last_long ? X_CLR : X_CMD);
                    chk((cyc - last_rise) >= X_PER, "R5 E period", cyc - last_rise, X_PER);
                end else begin
                    chk(cyc >= X_POWER, "R1 power-up wait", cyc, X_POWER);
                end
                last_rise = cyc;
                hi = 0;
            end
            if (!lcd_e && e_prev) begin
                chk(hi >= X_PW, "R5 E high width", hi, X_PW);
                if (ncap < 256) cap[ncap] = bus_now;
                ncap++;
                last_fall = cyc;
                seen_fall = 1'b1;
                hold_pend = 1'b1;
                last_long = (bus_now == 9'h001);
                lo = 0;
            end
            if (lcd_e) hi++; else lo++;
            if (req_ready && !ready_seen) begin
                ready_seen = 1'b1;
                ready_first = cyc;
                chk((cyc - last_fall) >= X_CMD, "R4 ready after entry-mode wait",
                    cyc - last_fall, X_CMD);
            end
            e_prev = lcd_e;
            bus_prev = bus_now;
        end
    end

    task automatic send(input logic kind, input logic [7:0] data,
                        input logic row, input logic [5:0] col);
        int old;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        old = ncap;
        req_kind = kind; req_data = data; req_row = row; req_col = col;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
        while (ncap == old) @(negedge clk);
        chk(ncap == old + 1, "R10 one strobe per request", ncap, old + 1);
    endtask

    logic [7:0] init_exp [0:3];
    initial begin
        init_exp[0] = 8'h38; init_exp[1] = 8'h0C; init_exp[2] = 8'h01; init_exp[3] = 8'h06;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 1'b0; req_data = 8'h00;
        req_row = 1'b0; req_col = 6'd0;
        repeat (5) @(negedge clk);
        chk(lcd_e == 1'b0, "R1 E low in reset", lcd_e, 0);
        chk(req_ready == 1'b0, "R4 ready low in reset", req_ready, 0);
        chk(lcd_rw == 1'b0, "R7 rw low in reset", lcd_rw, 0);
        rst_n = 1'b1;

        // R11: a request offered and withdrawn during start-up must vanish
        repeat (100) @(negedge clk);
        req_kind = 1'b0; req_data = 8'h5A; req_valid = 1'b1;
        repeat (20) @(negedge clk);
        chk(req_ready == 1'b0, "R4 ready low during start-up", req_ready, 0);
        req_valid = 1'b0;

        while (!req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(ncap == 4, "R11 withdrawn request ignored", ncap, 4);
        chk(lcd_e == 1'b0, "R11 bus quiet after start-up", lcd_e, 0);
        for (int i = 0; i < 4; i++) begin
            chk(cap[i] == {1'b0, init_exp[i]}, "R2 init byte", cap[i], {1'b0, init_exp[i]});
        end

        // R9: every row and every encodable column, clamp above 39
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 64; c++) begin
                int a;
                a = (r == 1 ? 64 : 0) + (c > 39 ? 39 : c);
                send(1'b1, 8'h00, r[0], c[5:0]);
                chk(cap[ncap-1] == {1'b0, 8'h80 | a[7:0]}, "R9 position byte",
                    cap[ncap-1], {1'b0, 8'h80 | a[7:0]});
            end
        end

        // R8: characters, including code 0x01 which must not take the long wait
        for (int i = 0; i < 32; i++) begin
            logic [7:0] ch;
            ch = 8'(i * 8 + 1);
            send(1'b0, ch, 1'b0, 6'd0);
            chk(cap[ncap-1] == {1'b1, ch}, "R8 character byte", cap[ncap-1], {1'b1, ch});
        end

        while (!req_ready) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog expired actual=%0h expected=%0h", 190000, 0);
            summary();
            $finish;
        end
    end

endmodule